// File: doc/BRIEF.md
# Serial Byte Transmitter with Selectable Interrupt Timing

The block serializes bytes onto a single asynchronous line. Bytes enter through a valid/ready port and queue in a four-entry buffer. A shift stage takes them from there and sends each one as a frame: a low start bit, eight data bits with the least significant bit first, and one or two high stop bits. Every bit lasts sixteen pulses of an externally supplied baud tick. When another byte is waiting, its start bit follows the last stop bit of the previous frame with no idle time between them.

Software picks the moment the single-cycle interrupt pulse appears through a two-bit mode input. The pulse can mark each hand-off from the buffer to the shift stage. It can mark only the hand-off that leaves the buffer empty. It can mark the point where the line has gone fully idle after the final stop bit. The fourth code stays silent. A status output reports when the shift stage and the buffer are both empty. The completion interrupt is never raised before that status is set.

Top module: `sertx_top`

## Requirements
- R1: While `rst_ni` is low, `txd_o` is 1, `sr_empty_o` is 1, `irq_o` is 0, `full_o` is 0 and `wr_ready_o` is 1, and the buffer holds no data.
- R2: The line idles at 1. A frame is a 0 start bit followed by the 8 data bits, least significant bit first. Each bit lasts exactly 16 baud ticks.
- R3: Each frame ends with one stop bit (value 1) when `two_stop_i` is 0 and two stop bits when it is 1. The input is sampled when the byte enters the shift stage.
- R4: When a byte is waiting as a frame ends, its start bit begins in the cycle right after the last stop bit, with no idle cycle.
- R5: The buffer holds 4 bytes. When it is full, `full_o` is 1 and `wr_ready_o` is 0. A write offered while the buffer is full is dropped and is never transmitted.
- R6: `sr_empty_o` is 1 exactly when the shift stage is idle and the buffer is empty. It is 0 while a byte is queued or being sent, including during its stop bits.
- R7: In mode `irq_mode_i`=2'b00, `irq_o` pulses high for one cycle, in the cycle after each byte moves from the buffer into the shift stage.
- R8: In mode 2'b10, `irq_o` pulses for one cycle after a byte moves into the shift stage, but only when the buffer is empty after that move.
- R9: In mode 2'b01, `irq_o` pulses for one cycle in the first cycle that `sr_empty_o` is 1 after a transmission, that is, after the last stop bit has ended. `sr_empty_o` is already 1 in that cycle.
- R10: Mode 2'b11 never raises `irq_o`.
- R11: The bit timer advances only in cycles where `baud_tick_i` is 1. With the tick held low, `txd_o` holds its current bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One pulse per oversampling step (16 per bit) |
| two_stop_i | input | 1 | 1 selects two stop bits, 0 selects one |
| irq_mode_i | input | 2 | Interrupt timing select: 00 per load, 10 on buffer drain, 01 on completion, 11 none |
| wr_valid_i | input | 1 | Write request |
| wr_data_i | input | 8 | Byte to queue |
| wr_ready_o | output | 1 | Buffer can accept a byte |
| full_o | output | 1 | Buffer is full |
| txd_o | output | 1 | Serial line output |
| sr_empty_o | output | 1 | Shift stage and buffer both empty |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest case is the completion interrupt at the end of a run of back-to-back frames with two stop bits. The pulse must land exactly on the cycle where the status flag rises, not inside the second stop bit. The bench streams several bytes with no gap and decodes every frame at mid-bit. At the boundary of each frame it checks that either the next start bit is already present or the status flag is set, and it checks the flag at every interrupt pulse in that mode. A full buffer is reached by holding the baud tick low while a fifth byte is pushed and a sixth is refused. The bench then releases the tick and confirms that exactly five frames come out.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    IRQ_ON_LOAD  = 2'b00,
    IRQ_ON_DONE  = 2'b01,
    IRQ_ON_DRAIN = 2'b10,
    IRQ_NONE     = 2'b11
  } irq_mode_e;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PMAX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == PMAX) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CFULL);
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int W   = 8,
  parameter int OVS = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         two_stop_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         txd_o,
  output logic         busy_o,
  output logic         frame_end_o
);
  localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BW = $clog2(W + 3);
  localparam logic [TW-1:0] TMAX  = TW'(OVS - 1);
  localparam logic [BW-1:0] LAST1 = BW'(W + 1);
  localparam logic [BW-1:0] LAST2 = BW'(W + 2);

  logic          busy_q, stop2_q;
  logic [W:0]    sr_q;
  logic [TW-1:0] tcnt_q;
  logic [BW-1:0] bidx_q;
  logic          bit_end, last_bit;

  assign bit_end     = busy_q & tick_i & (tcnt_q == TMAX);
  assign last_bit    = (bidx_q == (stop2_q ? LAST2 : LAST1));
  assign frame_end_o = bit_end & last_bit;
  assign busy_o      = busy_q;
  assign txd_o       = busy_q ? sr_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      stop2_q <= 1'b0;
      sr_q    <= '1;
      tcnt_q  <= '0;
      bidx_q  <= '0;
    end else if (load_i) begin
      busy_q  <= 1'b1;
      stop2_q <= two_stop_i;
      sr_q    <= {data_i, 1'b0};
      tcnt_q  <= '0;
      bidx_q  <= '0;
    end else if (frame_end_o) begin
      busy_q <= 1'b0;
    end else if (busy_q && tick_i) begin
      tcnt_q <= bit_end ? '0 : tcnt_q + 1'b1;
      if (bit_end) begin
        bidx_q <= bidx_q + 1'b1;
        sr_q   <= {1'b1, sr_q[W:1]}; // ones fill the stop bits
      end
    end
  end
endmodule

// File: rtl/sertx_irq.sv
module sertx_irq
  import sertx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       load_i,
  input  logic       buf_empty_i,
  input  logic       sr_empty_i,
  output logic       irq_o
);
  logic ld_q, sr_empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q       <= 1'b0;
      sr_empty_q <= 1'b1;
    end else begin
      ld_q       <= load_i;
      sr_empty_q <= sr_empty_i;
    end
  end

  // completion pulse keys off the flag itself, so it cannot lead it
  always_comb begin
    case (irq_mode_e'(mode_i))
      IRQ_ON_LOAD:  irq_o = ld_q;
      IRQ_ON_DRAIN: irq_o = ld_q & buf_empty_i;
      IRQ_ON_DONE:  irq_o = sr_empty_i & ~sr_empty_q;
      default:      irq_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int OVS   = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         baud_tick_i,
  input  logic         two_stop_i,
  input  logic [1:0]   irq_mode_i,
  input  logic         wr_valid_i,
  input  logic [W-1:0] wr_data_i,
  output logic         wr_ready_o,
  output logic         full_o,
  output logic         txd_o,
  output logic         sr_empty_o,
  output logic         irq_o
);
  logic         fifo_empty, fifo_full, fifo_push, fifo_pop;
  logic [W-1:0] fifo_data;
  logic         sr_busy, frame_end;

  assign fifo_push  = wr_valid_i & ~fifo_full;
  assign fifo_pop   = ~fifo_empty & (~sr_busy | frame_end);
  assign wr_ready_o = ~fifo_full;
  assign full_o     = fifo_full;
  assign sr_empty_o = ~sr_busy & fifo_empty;

  sertx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (fifo_push),
    .data_i (wr_data_i),
    .pop_i  (fifo_pop),
    .data_o (fifo_data),
    .empty_o(fifo_empty),
    .full_o (fifo_full)
  );

  sertx_shift #(.W(W), .OVS(OVS)) u_shift (
    .clk_i, .rst_ni,
    .tick_i     (baud_tick_i),
    .two_stop_i (two_stop_i),
    .load_i     (fifo_pop),
    .data_i     (fifo_data),
    .txd_o      (txd_o),
    .busy_o     (sr_busy),
    .frame_end_o(frame_end)
  );

  sertx_irq u_irq (
    .clk_i, .rst_ni,
    .mode_i     (irq_mode_i),
    .load_i     (fifo_pop),
    .buf_empty_i(fifo_empty),
    .sr_empty_i (sr_empty_o),
    .irq_o      (irq_o)
  );
endmodule

module sertx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       baud_tick_i,
  input logic [1:0] irq_mode_i,
  input logic       wr_valid_i,
  input logic       full_o,
  input logic       txd_o,
  input logic       sr_empty_o,
  input logic       irq_o,
  input logic       pop_i
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R7
  AST_DONE_AFTER_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_mode_i == 2'b01 && irq_o) |-> sr_empty_o); // R9
  AST_RESERVED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_mode_i == 2'b11) |-> !irq_o); // R10
  AST_FULL_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(wr_valid_i)); // R5
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_empty_o |-> txd_o); // R6
  AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txd_o) |-> ($past(baud_tick_i) || $past(pop_i))); // R11
endmodule

bind sertx_top sertx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .baud_tick_i(baud_tick_i),
  .irq_mode_i (irq_mode_i),
  .wr_valid_i (wr_valid_i),
  .full_o     (full_o),
  .txd_o      (txd_o),
  .sr_empty_o (sr_empty_o),
  .irq_o      (irq_o),
  .pop_i      (fifo_pop)
);

// File: tb/tb_sertx_top.sv
`timescale 1ns/1ps
module tb_sertx_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       two_stop = 1'b0;
  logic [1:0] mode = 2'b11;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready, full, txd, sr_empty, irq;

  int checks = 0, fails = 0, irq_seen = 0;

  always #2.5 clk = ~clk;

  sertx_top dut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .two_stop_i(two_stop),
    .irq_mode_i(mode), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_ready_o(wr_ready), .full_o(full), .txd_o(txd),
    .sr_empty_o(sr_empty), .irq_o(irq)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic       two;
    logic [2:0] n;
    logic [7:0] base;
    logic [2:0] exp_irq;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b1, 3'd3, 8'hA5, 3'd3},
    '{2'b10, 1'b0, 3'd3, 8'h3C, 3'd2},
    '{2'b01, 1'b1, 3'd2, 8'h81, 3'd1},
    '{2'b01, 1'b0, 3'd1, 8'h00, 3'd1},
    '{2'b11, 1'b1, 3'd2, 8'hFF, 3'd0},
    '{2'b10, 1'b1, 3'd1, 8'h5A, 3'd1},
    '{2'b00, 1'b0, 3'd5, 8'h10, 3'd5}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // R9: flag must already be set whenever the completion pulse is seen
  always @(negedge clk) begin
    if (rst_n && irq) begin
      irq_seen++;
      if (mode == 2'b01) chk(sr_empty == 1'b1, "R9 flag at irq", sr_empty, 1);
    end
  end

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // called at a negedge; assumes tick high every cycle from the start bit on
  task automatic decode(input logic [7:0] exp, input bit two, input bit last);
    logic [7:0] got;
    while (txd) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(txd == 1'b0, "R2 start bit", txd, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (16) @(negedge clk);
      got[i] = txd;
    end
    chk(got == exp, "R2 data lsb first", got, exp);
    repeat (16) @(negedge clk);
    chk(txd == 1'b1, "R3 stop bit 1", txd, 1);
    if (two) begin
      repeat (16) @(negedge clk);
      chk(txd == 1'b1, "R3 stop bit 2", txd, 1);
    end
    chk(sr_empty == 1'b0, "R6 busy in stop", sr_empty, 0);
    repeat (8) @(negedge clk);
    if (!last) begin
      chk(txd == 1'b0, "R4 no gap", txd, 0);
    end else begin
      chk(sr_empty == 1'b1, "R6 empty after last stop", sr_empty, 1);
      chk(txd == 1'b1, "R3 line idle after stop", txd, 1);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd == 1'b1 && sr_empty == 1'b1 && irq == 1'b0, "R1 reset outputs", {txd, sr_empty, irq}, 3'b110);
    chk(wr_ready == 1'b1 && full == 1'b0, "R1 reset buffer", {wr_ready, full}, 2'b10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VECS[v]) begin
      mode     = VECS[v].mode;
      two_stop = VECS[v].two;
      irq_seen = 0;
      fork
        for (int i = 0; i < int'(VECS[v].n); i++) push_byte(VECS[v].base + 8'(i * 8'h4B));
        for (int i = 0; i < int'(VECS[v].n); i++)
          decode(VECS[v].base + 8'(i * 8'h4B), VECS[v].two, i == int'(VECS[v].n) - 1);
      join
      repeat (4) @(negedge clk);
      case (VECS[v].mode)
        2'b00:   chk(irq_seen == int'(VECS[v].exp_irq), "R7 irq per load", irq_seen, VECS[v].exp_irq);
        2'b10:   chk(irq_seen == int'(VECS[v].exp_irq), "R8 irq on drain", irq_seen, VECS[v].exp_irq);
        2'b01:   chk(irq_seen == int'(VECS[v].exp_irq), "R9 irq on done", irq_seen, VECS[v].exp_irq);
        default: chk(irq_seen == int'(VECS[v].exp_irq), "R10 reserved mode", irq_seen, VECS[v].exp_irq);
      endcase
    end

    // R7: exact pulse cycle after a single load
    mode = 2'b00;
    push_byte(8'h77);
    @(negedge clk);
    chk(irq == 1'b1, "R7 pulse cycle", irq, 1);
    chk(txd == 1'b0, "R2 start after load", txd, 0);
    @(negedge clk);
    chk(irq == 1'b0, "R7 pulse width", irq, 0);
    while (!sr_empty) @(negedge clk);
    repeat (2) @(negedge clk);

    // R5 / R11: fill the buffer with the tick held low
    mode     = 2'b11;
    two_stop = 1'b0;
    tick     = 1'b0;
    irq_seen = 0;
    for (int i = 0; i < 5; i++) push_byte(8'hC0 + 8'(i));
    chk(full == 1'b1, "R5 full flag", full, 1);
    chk(wr_ready == 1'b0, "R5 ready low", wr_ready, 0);
    chk(sr_empty == 1'b0, "R6 queued not empty", sr_empty, 0);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = 8'hEE;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk(txd == 1'b0, "R11 held without tick", txd, 0);
    tick = 1'b1;
    for (int i = 0; i < 5; i++) decode(8'hC0 + 8'(i), 1'b0, i == 4);
    repeat (40) @(negedge clk);
    chk(txd == 1'b1 && sr_empty == 1'b1, "R5 refused byte not sent", {txd, sr_empty}, 2'b11);
    chk(irq_seen == 0, "R10 silent while full", irq_seen, 0);

    // R1: asynchronous reset mid-frame
    mode = 2'b00;
    push_byte(8'h00);
    push_byte(8'h01);
    repeat (50) @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk(txd == 1'b1 && sr_empty == 1'b1 && irq == 1'b0, "R1 async reset", {txd, sr_empty, irq}, 3'b110);
    chk(full == 1'b0 && wr_ready == 1'b1, "R1 buffer cleared", {full, wr_ready}, 2'b01);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule